// File: doc/BRIEF.md
# Space Vector PWM Sector Timer

This block turns a rotating reference vector, given as a signed angle in whole degrees and a modulation magnitude, into the six gate drives of a three-leg inverter. It brings the angle into the 0 to 359 degree range, works out which of the six 60-degree sectors holds the vector and how far into that sector it sits, and from that derives the dwell times of the two adjacent active vectors and of the zero vectors for one switching period.

The dwell times are spread over the three phases through a per-sector table. Half of the zero-vector time sits at each end of the period, so every phase duty is centred in the period. Across a full turn of the angle the duties trace the M-shaped modulating wave. Each duty is compared with an up/down triangular carrier. New inputs take effect only at the carrier valley. A duty therefore never changes while its pulse is being output, and each leg drives its upper and lower switch as an exact complementary pair.

Top module: `svpwm_gate_gen`

## Requirements
- R1: While `rst` is high, all six gate outputs are low and `sector_o` reads 0.
- R2: From the second clock edge after reset is released, `gate_lo_o[p]` is the inverse of `gate_hi_o[p]` for every leg p (bit 0 = phase a, bit 1 = phase b, bit 2 = phase c).
- R3: The angle is a signed whole-degree value. Values above +180 are treated as +180 and values below -180 as -180. A negative angle has 360 added. `sector_o` = floor(angle/60) + 1 (1 to 6), and the offset inside the sector is theta = angle - 60*(sector_o-1), which is in 0..59.
- R4: With the sine code S(k) = round(4095*sin(k degrees)), the carrier top P and the magnitude m (1024 means 1.0), T1 = floor(P*m*S(60-theta)/2^22), T2 = floor(P*m*S(theta)/2^22) and T0 = P - T1 - T2.
- R5: When T1 + T2 > P, T1 is replaced by floor(P*Q/4096) with Q = floor((4096*S(60-theta) + (S(60-theta)+S(theta))/2) / (S(60-theta)+S(theta))), T2 by P - T1, and T0 becomes 0.
- R6: With h = floor(T0/2), the phase duties (a, b, c) per sector are: 1: (T1+T2+h, T2+h, h); 2: (T1+h, T1+T2+h, h); 3: (h, T1+T2+h, T2+h); 4: (h, T1+h, T1+T2+h); 5: (T2+h, h, T1+T2+h); 6: (T1+T2+h, h, T1+h).
- R7: The carrier counts up from 0 to P-1 and back down, so one period is 2P clock cycles. P is `carrier_top_i`, raised to 2 when smaller. During each period the upper gate of a phase with duty d is high for exactly 2d cycles, as one run centred on the carrier peak.
- R8: The angle, magnitude and carrier top are taken only at the carrier valley. A change in mid-period never shortens or stretches a pulse in progress, so every complete high run of a leg has the length set by either the old inputs or the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| angle_i | input | ANG_W (9) | Signed reference angle in degrees |
| mag_i | input | M_W (11) | Modulation magnitude, 1024 = 1.0 |
| carrier_top_i | input | CNT_W (16) | Carrier half-period P in clock cycles |
| gate_hi_o | output | 3 | Upper switch drives, phases a, b, c |
| gate_lo_o | output | 3 | Lower switch drives, phases a, b, c |
| sector_o | output | 3 | Current sector, 1 to 6 (0 in reset) |

## Verification
The bench builds the block with its default widths: a 9-bit angle, an 11-bit magnitude reaching almost 2.0, a 16-bit carrier counter and 12-bit sine codes. The magnitude range lets random vectors fall well past the point where T1 + T2 exceeds P, so the clamp gets as much exercise as the linear region. Carrier tops stay small (2 to 60) so that many periods fit in a run, and P = 2 and P = 0 reach the smallest carrier. The 9-bit angle reaches values beyond ±180, so the clamp and the wrap into 0..359 are both driven at sector boundaries.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

  localparam real PI_R     = 3.14159265358979323846;
  localparam int  SEC_NUM  = 6;
  localparam int  SEC_SPAN = 60;

  // Quarter-wave sine code, full scale (2^bits - 1), rounded to nearest.
  function automatic int sin_code(input int deg, input int bits);
    real v;
    v = $sin(deg * PI_R / 180.0) * ((2.0 ** bits) - 1.0);
    return $rtoi(v + 0.5);
  endfunction

  // Share of the period given to the first active vector when saturated,
  // scaled by 2^bits.
  function automatic int split_code(input int theta, input int bits);
    int sa;
    int sb;
    sa = sin_code(SEC_SPAN - theta, bits);
    sb = sin_code(theta, bits);
    return ((sa << bits) + (sa + sb) / 2) / (sa + sb);
  endfunction

endpackage

// File: rtl/svpwm_angle.sv
module svpwm_angle #(
  parameter int ANG_W = 9
) (
  input  logic signed [ANG_W-1:0] angle_i,
  output logic        [2:0]       sec_idx_o,
  output logic        [5:0]       theta_o
);
  import svpwm_pkg::*;

  int a_deg;
  int idx;

  always_comb begin
    a_deg = int'(angle_i);
    if (a_deg > 180)  a_deg = 180;
    if (a_deg < -180) a_deg = -180;
    if (a_deg < 0)    a_deg = a_deg + 360;
    idx = 0;
    for (int k = 1; k < SEC_NUM; k++) begin
      if (a_deg >= SEC_SPAN * k) idx = k;
    end
    sec_idx_o = 3'(idx);
    theta_o   = 6'(a_deg - SEC_SPAN * idx);
  end

endmodule

// File: rtl/svpwm_dwell.sv
module svpwm_dwell #(
  parameter int CNT_W  = 16,
  parameter int M_W    = 11,
  parameter int M_FRAC = 10,
  parameter int SIN_W  = 12
) (
  input  logic [CNT_W-1:0] top_i,
  input  logic [M_W-1:0]   mag_i,
  input  logic [5:0]       theta_i,
  output logic [CNT_W-1:0] t1_o,
  output logic [CNT_W-1:0] t2_o,
  output logic [CNT_W-1:0] t0_o
);
  import svpwm_pkg::*;

  localparam int PW = CNT_W + M_W + SIN_W;
  localparam int QW = SIN_W + 1;
  localparam int CW = CNT_W + QW;

  logic [SIN_W-1:0] sin_rom   [0:90];
  logic [QW-1:0]    split_rom [0:SEC_SPAN];

  for (genvar k = 0; k <= 90; k++) begin : g_sin
    localparam int SV = sin_code(k, SIN_W);
    assign sin_rom[k] = SIN_W'(SV);
  end

  for (genvar k = 0; k <= SEC_SPAN; k++) begin : g_split
    localparam int QV = split_code(k, SIN_W);
    assign split_rom[k] = QW'(QV);
  end

  logic [6:0]       idx_a, idx_b;
  logic [PW-1:0]    prod_a, prod_b;
  logic [CNT_W:0]   raw1, raw2;
  logic [CNT_W+1:0] raw_sum;
  logic [CW-1:0]    prod_c;
  logic [CNT_W-1:0] fit1;

  assign idx_b = {1'b0, theta_i};
  assign idx_a = 7'(SEC_SPAN) - idx_b;

  always_comb begin
    prod_a  = PW'(top_i) * PW'(mag_i) * PW'(sin_rom[idx_a]);
    prod_b  = PW'(top_i) * PW'(mag_i) * PW'(sin_rom[idx_b]);
    raw1    = (CNT_W+1)'(prod_a >> (M_FRAC + SIN_W));
    raw2    = (CNT_W+1)'(prod_b >> (M_FRAC + SIN_W));
    raw_sum = (CNT_W+2)'(raw1) + (CNT_W+2)'(raw2);
    prod_c  = CW'(top_i) * CW'(split_rom[theta_i]);
    fit1    = CNT_W'(prod_c >> SIN_W);
    if (raw_sum > (CNT_W+2)'(top_i)) begin
      t1_o = fit1;
      t2_o = top_i - fit1;
    end else begin
      t1_o = CNT_W'(raw1);
      t2_o = CNT_W'(raw2);
    end
    t0_o = top_i - t1_o - t2_o;
  end

endmodule

// File: rtl/svpwm_carrier.sv
module svpwm_carrier #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] top_o,
  output logic             valley_o
);
  logic [CNT_W-1:0] cnt_q, top_q;
  logic             down_q;

  assign valley_o = down_q && (cnt_q == '0);
  assign cnt_o    = cnt_q;
  assign top_o    = top_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      down_q <= 1'b1;
      top_q  <= '1;
    end else if (down_q) begin
      if (cnt_q == '0) begin
        down_q <= 1'b0;
        top_q  <= top_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      if (cnt_q == top_q - 1'b1) down_q <= 1'b1;
      else                       cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R7: the triangle never reaches the latched top value
  p_cnt_below_top_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q < top_q)
    else $error("carrier count reached top");

endmodule

// File: rtl/svpwm_gate_gen.sv
module svpwm_gate_gen #(
  parameter int ANG_W  = 9,
  parameter int M_W    = 11,
  parameter int M_FRAC = 10,
  parameter int CNT_W  = 16,
  parameter int SIN_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ANG_W-1:0] angle_i,
  input  logic        [M_W-1:0]   mag_i,
  input  logic        [CNT_W-1:0] carrier_top_i,
  output logic        [2:0]       gate_hi_o,
  output logic        [2:0]       gate_lo_o,
  output logic        [2:0]       sector_o
);
  localparam int               LEGS    = 3;
  localparam logic [CNT_W-1:0] TOP_MIN = CNT_W'(2);

  logic [CNT_W-1:0] top_eff, top_q, cnt_q, t1, t2, t0, half;
  logic             valley;
  logic [2:0]       sec_idx;
  logic [5:0]       theta;
  logic [LEGS-1:0][CNT_W-1:0] duty_d, duty_q;
  logic [LEGS-1:0]  leg_on, hi_q, lo_q;
  logic [2:0]       sector_q;

  assign top_eff = (carrier_top_i < TOP_MIN) ? TOP_MIN : carrier_top_i;

  svpwm_angle #(.ANG_W(ANG_W)) u_angle (
    .angle_i   (angle_i),
    .sec_idx_o (sec_idx),
    .theta_o   (theta)
  );

  svpwm_dwell #(.CNT_W(CNT_W), .M_W(M_W), .M_FRAC(M_FRAC), .SIN_W(SIN_W)) u_dwell (
    .top_i   (top_eff),
    .mag_i   (mag_i),
    .theta_i (theta),
    .t1_o    (t1),
    .t2_o    (t2),
    .t0_o    (t0)
  );

  svpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk      (clk),
    .rst      (rst),
    .top_i    (top_eff),
    .cnt_o    (cnt_q),
    .top_o    (top_q),
    .valley_o (valley)
  );

  assign half = t0 >> 1;

  // Per-sector spreading of the dwell times, zero time split at both ends
  always_comb begin
    case (sec_idx)
      3'd0:    duty_d = {half,           t2 + half,      t1 + t2 + half};
      3'd1:    duty_d = {half,           t1 + t2 + half, t1 + half};
      3'd2:    duty_d = {t2 + half,      t1 + t2 + half, half};
      3'd3:    duty_d = {t1 + t2 + half, t1 + half,      half};
      3'd4:    duty_d = {t1 + t2 + half, half,           t2 + half};
      default: duty_d = {t1 + half,      half,           t1 + t2 + half};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q   <= '0;
      sector_q <= 3'd0;
    end else if (valley) begin
      duty_q   <= duty_d;
      sector_q <= sec_idx + 3'd1;
    end
  end

  for (genvar p = 0; p < LEGS; p++) begin : g_leg
    assign leg_on[p] = (cnt_q >= top_q - duty_q[p]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= leg_on;
      lo_q <= ~leg_on;
    end
  end

  assign gate_hi_o = hi_q;
  assign gate_lo_o = lo_q;
  assign sector_o  = sector_q;

  // R2: each leg drives an exact complementary pair once out of reset
  p_leg_comp_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((gate_hi_o ^ gate_lo_o) == 3'b111))
    else $error("leg pair not complementary");

  // R3: in-sector offset and sector index stay within one sector span
  p_theta_span_r3: assert property (@(posedge clk) disable iff (rst)
    (theta < 6'd60) && (sec_idx < 3'd6))
    else $error("angle split out of range");

  // R3: reported sector is 1..6 once loaded
  p_sector_range_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sector_o >= 3'd1 && sector_o <= 3'd6))
    else $error("sector out of range");

  // R5: active dwell times never exceed the period
  p_dwell_fit_r5: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, t1} + {1'b0, t2}) <= {1'b0, top_eff})
    else $error("dwell times overflow period");

  // R6: latched duties never exceed the latched carrier top
  p_duty_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (duty_q[0] <= top_q) && (duty_q[1] <= top_q) && (duty_q[2] <= top_q))
    else $error("duty above carrier top");

  // R8: duties only move at the carrier valley
  p_duty_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !valley |=> $stable(duty_q))
    else $error("duty changed mid-period");

endmodule

// File: tb/svpwm_gate_gen_bench.sv
module svpwm_gate_gen_bench;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic signed [8:0] angle = '0;
  logic [10:0]       mag = '0;
  logic [15:0]       ptop = 16'd10;
  logic [2:0]        g_hi, g_lo, sector;

  int checks = 0;
  int fails  = 0;
  int prev_p = 10;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  svpwm_gate_gen u_svpwm_gate_gen (
    .clk           (clk),
    .rst           (rst),
    .angle_i       (angle),
    .mag_i         (mag),
    .carrier_top_i (ptop),
    .gate_hi_o     (g_hi),
    .gate_lo_o     (g_lo),
    .sector_o      (sector)
  );

  function automatic int s_code(input int k);
    return $rtoi($sin(k * 3.14159265358979323846 / 180.0) * 4095.0 + 0.5);
  endfunction

  function automatic int eff_p(input int p);
    return (p < 2) ? 2 : p;
  endfunction

  task automatic model(input int ang, input int m, input int p,
                       output int da, output int db, output int dc,
                       output int sec, output bit clamped);
    int a, i, th, sa, sb, t1, t2, t0, h, q, pp;
    longint la, lb;
    pp = eff_p(p);
    a = ang;
    if (a > 180)  a = 180;
    if (a < -180) a = -180;
    if (a < 0)    a = a + 360;
    i = a / 60;
    th = a - 60 * i;
    sec = i + 1;
    sa = s_code(60 - th);
    sb = s_code(th);
    la = (longint'(pp) * m * sa) >> 22;
    lb = (longint'(pp) * m * sb) >> 22;
    t1 = int'(la);
    t2 = int'(lb);
    clamped = (t1 + t2 > pp);
    if (clamped) begin
      q  = ((sa * 4096) + (sa + sb) / 2) / (sa + sb);
      t1 = int'((longint'(pp) * q) >> 12);
      t2 = pp - t1;
    end
    t0 = pp - t1 - t2;
    h  = t0 / 2;
    case (i)
      0: begin da = t1 + t2 + h; db = t2 + h;      dc = h;           end
      1: begin da = t1 + h;      db = t1 + t2 + h; dc = h;           end
      2: begin da = h;           db = t1 + t2 + h; dc = t2 + h;      end
      3: begin da = h;           db = t1 + h;      dc = t1 + t2 + h; end
      4: begin da = t2 + h;      db = h;           dc = t1 + t2 + h; end
      default: begin da = t1 + t2 + h; db = h;     dc = t1 + h;      end
    endcase
  endtask

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Apply one vector, let it settle, then measure one full carrier period.
  task automatic apply(input int ang, input int m, input int p, input string tag);
    int da, db, dc, sec, pp, na, nb, nc, bad;
    bit cl;
    string t;
    model(ang, m, p, da, db, dc, sec, cl);
    t = cl ? "R5" : tag;
    pp = eff_p(p);
    @(negedge clk);
    angle = 9'(ang);
    mag   = 11'(m);
    ptop  = 16'(p);
    repeat (4 * prev_p + 4 * pp + 6) @(negedge clk);
    na = 0; nb = 0; nc = 0; bad = 0;
    for (int c = 0; c < 2 * pp; c++) begin
      @(negedge clk);
      na += int'(g_hi[0]);
      nb += int'(g_hi[1]);
      nc += int'(g_hi[2]);
      if ((g_hi ^ g_lo) != 3'b111) bad++;
    end
    // R6 / R7: high time per period is twice the phase duty
    check_eq(t, "phase a high cycles (R6)", na, 2 * da);
    check_eq(t, "phase b high cycles (R7)", nb, 2 * db);
    check_eq(t, "phase c high cycles (R6)", nc, 2 * dc);
    check_eq("R3", "sector", int'(sector), sec);
    check_eq("R2", "non-complementary cycles", bad, 0);
    prev_p = pp;
  endtask

  // R8: change magnitude at an arbitrary point and check every full run length.
  task automatic mid_change(input int offs);
    int dA, dB, x1, x2, s1, run, seen_b;
    bit cl, started;
    model(20, 500, 40, dA, x1, x2, s1, cl);
    model(20, 900, 40, dB, x1, x2, s1, cl);
    apply(20, 500, 40, "R4");
    repeat (offs) @(negedge clk);
    mag = 11'd900;
    started = 1'b0;
    run = 0;
    seen_b = 0;
    repeat (640) begin
      @(negedge clk);
      if (g_hi[0]) begin
        if (started) run++;
      end else begin
        if (started && run > 0) begin
          checks++;
          if (run != 2 * dA && run != 2 * dB) begin
            fails++;
            $display("FAIL R8 run length: actual %0d expected %0d or %0d", run, 2 * dA, 2 * dB);
          end
          if (run == 2 * dB) seen_b++;
        end
        started = 1'b1;
        run = 0;
      end
    end
    check_eq("R8", "runs with new magnitude seen", (seen_b > 0) ? 1 : 0, 1);
    prev_p = 40;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check_eq("R1", "upper gates in reset", int'(g_hi), 0);
    check_eq("R1", "lower gates in reset", int'(g_lo), 0);
    check_eq("R1", "sector in reset", int'(sector), 0);
    rst = 1'b0;

    // R3: angle wrapping, clamping and sector edges
    apply(0,    800, 30, "R3");
    apply(59,   800, 30, "R3");
    apply(60,   800, 30, "R3");
    apply(-1,   800, 30, "R3");
    apply(-60,  700, 24, "R3");
    apply(180,  700, 24, "R3");
    apply(-180, 700, 24, "R3");
    apply(220,  700, 24, "R3");
    apply(-250, 700, 24, "R3");
    apply(135,  600, 36, "R4");
    // R5: saturated magnitude
    apply(30,  2047, 50, "R5");
    apply(0,   2047, 50, "R5");
    apply(250, 1800, 44, "R5");
    // R4: zero magnitude gives pure zero vectors
    apply(90,     0, 20, "R4");
    // R7: smallest carrier and a raised-to-minimum top
    apply(45,   600,  2, "R7");
    apply(45,   600,  0, "R7");
    apply(200,  900, 60, "R7");

    // R8: mid-period updates at several offsets
    mid_change(7);
    mid_change(33);
    mid_change(61);

    for (int n = 0; n < 80; n++) begin
      int ra, rm, rp;
      ra = int'($urandom_range(0, 511)) - 256;
      rm = int'($urandom_range(0, 2047));
      rp = int'($urandom_range(2, 60));
      apply(ra, rm, rp, "R4");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule